// File: doc/BRIEF.md
# Line Frequency Calculation Sequencer

This block is the control sequencer that turns a mains pulse count into a normalized frequency value. It drives an external pulse counter, which counts a fixed-rate sample clock over one hundred periods of the line voltage, and an external restoring divider, which forms the ratio of two 24-bit operands. The sequencer itself holds no counting or dividing datapath: it issues start strobes, waits for completion, moves operands and keeps the result.

A measurement completes on each four-second tick. After reset the sequencer waits for the first tick, then starts the counter. Counter completion is remembered, but the count is only read at the next tick, so results refresh at the tick rate. On that tick the sequencer loads the 50 Hz reference count (the pulses in exactly one hundred periods of a 50 Hz line) as the dividend and the measured count as the divisor. It starts the divider, waits for its done flag, stores the quotient as the frequency, and restarts the counter at once. The frequency word is 24-bit two's complement with the binary point after the second most significant bit, so 50 Hz reads 0x400000. If a tick arrives before the counter has finished, a timeout flag is raised, the old frequency is kept and counting restarts.

Top module: `lfc_sequencer`

## Requirements
- R1: While rst_n is low (sampled on the clock), freq_o and timeout_o are zero and all three strobes are low. After reset no strobe is issued until a tick arrives.
- R2: A tick while idle makes cnt_start_o high for exactly one cycle, starting in the cycle after the tick was sampled.
- R3: While waiting for the count, counter completion alone does not advance the sequence. cnt_done_i may be a one-cycle pulse, which is remembered. The count is read (cnt_rd_o high for one cycle) in the cycle after a tick that comes with or after completion.
- R4: In the read cycle the sequencer captures ref_count_i as div_dividend_o and the zero-extended cnt_value_i as div_divisor_o. It holds both until the next read. div_start_o pulses for one cycle in the cycle after cnt_rd_o.
- R5: The divider wait lasts until div_done_i. freq_o takes the value of div_quot_i as presented in the cycle after div_done_i, and shows it from the following cycle. At no other time does freq_o change, except by reset.
- R6: In the cycle after the store, cnt_start_o pulses again without waiting for a tick.
- R7: A tick while waiting for a count that has not completed sets timeout_o, leaves freq_o unchanged, and pulses cnt_start_o in the next cycle.
- R8: timeout_o stays set until the next stored result clears it.
- R9: Ticks that arrive between the read and the store have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Four-second interval pulse, one cycle wide |
| cnt_start_o | output | 1 | Clears and starts the external pulse counter |
| cnt_done_i | input | 1 | Counter has counted one hundred line periods |
| cnt_rd_o | output | 1 | Count read strobe; count is captured in this cycle |
| cnt_value_i | input | CNT_W (15) | Pulse count held by the counter |
| div_start_o | output | 1 | Starts the external divider |
| div_done_i | input | 1 | Divider quotient is ready |
| div_dividend_o | output | DATA_W (24) | Dividend: 50 Hz reference count |
| div_divisor_o | output | DATA_W (24) | Divisor: measured count, zero-extended |
| div_quot_i | input | DATA_W (24) | Quotient from the divider |
| ref_count_i | input | DATA_W (24) | Stored 50 Hz reference count |
| freq_o | output | DATA_W (24) | Normalized frequency, 0x400000 = 50 Hz |
| timeout_o | output | 1 | Last interval ended with no completed count |

## Verification
Every result has a fixed delay after its stimulus. A start or read strobe follows the sampling edge of the tick by one cycle, and the operands follow the read strobe by one cycle. The frequency word and the restart strobe show up two cycles after div_done_i is sampled. The bench drives and samples on the falling edge and steps an exact number of edges per stage. It checks each output in the one cycle it is due, and it checks that the output is not yet there one cycle early. Hold behaviour is checked by changing the operand and quotient inputs after capture and confirming that the outputs keep their values.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
// Package: shared sequencer state encoding.
// Assumes: one state register of STATE_W bits in lfc_fsm.
package lfc_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE        = 3'd0,
        ST_START_COUNT = 3'd1,
        ST_WAIT_COUNT  = 3'd2,
        ST_READ_COUNT  = 3'd3,
        ST_START_DIV   = 3'd4,
        ST_WAIT_DIV    = 3'd5,
        ST_STORE       = 3'd6
    } seq_state_e;
endpackage

// File: rtl/lfc_fsm.sv
`timescale 1ns/1ps
// Module: lfc_fsm
// Control state machine of the frequency sequencer. It decodes one-cycle
// strobes from the state, remembers counter completion, and flags an
// interval that ended without a count.
// Assumes: tick_i and cnt_done_i are synchronous to clk, and div_done_i
// is never raised in the cycle of div_start_o.
module lfc_fsm
    import lfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic cnt_done_i,
    input  logic div_done_i,
    output logic cnt_start_o,
    output logic cnt_rd_o,
    output logic div_start_o,
    output logic store_o,
    output logic timeout_evt_o
);
    seq_state_e state_q, state_d;
    logic       done_seen_q;
    logic       count_ready;

    assign count_ready = done_seen_q | cnt_done_i;

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remembers a completed count until the next counter start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_seen_q <= 1'b0;
        else if (state_q == ST_START_COUNT)
            done_seen_q <= 1'b0;
        else if (state_q == ST_WAIT_COUNT && cnt_done_i)
            done_seen_q <= 1'b1;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (tick_i) state_d = ST_START_COUNT;
            ST_START_COUNT: state_d = ST_WAIT_COUNT;
            ST_WAIT_COUNT:  if (tick_i)
                                state_d = count_ready ? ST_READ_COUNT : ST_START_COUNT;
            ST_READ_COUNT:  state_d = ST_START_DIV;
            ST_START_DIV:   state_d = ST_WAIT_DIV;
            ST_WAIT_DIV:    if (div_done_i) state_d = ST_STORE;
            ST_STORE:       state_d = ST_START_COUNT;
            default:        state_d = ST_IDLE;
        endcase
    end

    // Strobe decode from the current state.
    always_comb begin
        cnt_start_o   = (state_q == ST_START_COUNT);
        cnt_rd_o      = (state_q == ST_READ_COUNT);
        div_start_o   = (state_q == ST_START_DIV);
        store_o       = (state_q == ST_STORE);
        timeout_evt_o = (state_q == ST_WAIT_COUNT) && tick_i && !count_ready;
    end

    // R2: the counter start strobe lasts one cycle.
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_start_o |=> !cnt_start_o);

    // R3: a count read always follows a sampled tick.
    a_r3_read_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_rd_o) |-> $past(tick_i));

    // R4: the divider start follows the read by one cycle.
    a_r4_div_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd_o |=> div_start_o);

    // R6: counting restarts right after a store.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |=> cnt_start_o);
endmodule

// File: rtl/lfc_operands.sv
`timescale 1ns/1ps
// Module: lfc_operands
// Divider operand registers. It snapshots the reference count and the
// measured count in the read cycle and holds them for the divider.
// Assumes: CNT_W <= DATA_W; the count is unsigned and is zero-extended.
module lfc_operands #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] ref_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] dividend_o,
    output logic [DATA_W-1:0] divisor_o
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic [DATA_W-1:0] cnt_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign cnt_ext = {{PAD_W{1'b0}}, cnt_i};
        end else begin : g_nopad
            assign cnt_ext = cnt_i[DATA_W-1:0];
        end
    endgenerate

    // Operand capture on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dividend_o <= '0;
            divisor_o  <= '0;
        end else if (load_i) begin
            dividend_o <= ref_i;
            divisor_o  <= cnt_ext;
        end
    end

    // R4: operands hold between reads.
    a_r4_operands_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i)) |-> ($stable(dividend_o) && $stable(divisor_o)));
endmodule

// File: rtl/lfc_result.sv
`timescale 1ns/1ps
// Module: lfc_result
// Frequency result and timeout flag. It keeps the last quotient and
// flags an interval that ended with no count.
// Assumes: the quotient is held by the divider while store_i is high.
module lfc_result #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_i,
    input  logic              timeout_evt_i,
    input  logic [DATA_W-1:0] quot_i,
    output logic [DATA_W-1:0] freq_o,
    output logic              timeout_o
);
    // Frequency register, written only on store.
    always_ff @(posedge clk) begin
        if (!rst_n)       freq_o <= '0;
        else if (store_i) freq_o <= quot_i;
    end

    // Timeout flag: set by a missed interval, cleared by a store.
    always_ff @(posedge clk) begin
        if (!rst_n)             timeout_o <= 1'b0;
        else if (timeout_evt_i) timeout_o <= 1'b1;
        else if (store_i)       timeout_o <= 1'b0;
    end

    // R5: the frequency changes only after a store.
    a_r5_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(store_i)) |-> $stable(freq_o));

    // R8: a store leaves the timeout flag clear.
    a_r8_timeout_clear: assert property (@(posedge clk) disable iff (!rst_n)
        store_i |=> !timeout_o);
endmodule

// File: rtl/lfc_sequencer.sv
`timescale 1ns/1ps
// Module: lfc_sequencer (top)
// Runs the line frequency measurement: it starts the counter, reads the
// count on the interval tick, feeds the divider and keeps the quotient.
// Assumes: external counter and divider handshake as described in the
// brief; the divider holds its quotient one cycle after done.
module lfc_sequencer #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic              cnt_start_o,
    input  logic              cnt_done_i,
    output logic              cnt_rd_o,
    input  logic [CNT_W-1:0]  cnt_value_i,
    output logic              div_start_o,
    input  logic              div_done_i,
    output logic [DATA_W-1:0] div_dividend_o,
    output logic [DATA_W-1:0] div_divisor_o,
    input  logic [DATA_W-1:0] div_quot_i,
    input  logic [DATA_W-1:0] ref_count_i,
    output logic [DATA_W-1:0] freq_o,
    output logic              timeout_o
);
    logic store;
    logic timeout_evt;

    lfc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .cnt_done_i    (cnt_done_i),
        .div_done_i    (div_done_i),
        .cnt_start_o   (cnt_start_o),
        .cnt_rd_o      (cnt_rd_o),
        .div_start_o   (div_start_o),
        .store_o       (store),
        .timeout_evt_o (timeout_evt)
    );

    lfc_operands #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ops (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_rd_o),
        .ref_i      (ref_count_i),
        .cnt_i      (cnt_value_i),
        .dividend_o (div_dividend_o),
        .divisor_o  (div_divisor_o)
    );

    lfc_result #(.DATA_W(DATA_W)) u_res (
        .clk           (clk),
        .rst_n         (rst_n),
        .store_i       (store),
        .timeout_evt_i (timeout_evt),
        .quot_i        (div_quot_i),
        .freq_o        (freq_o),
        .timeout_o     (timeout_o)
    );

    // R7: a timeout only rises after a sampled tick.
    a_r7_timeout_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(tick_i));
endmodule

// File: tb/lfc_sequencer_tb_top.sv
`timescale 1ns/1ps
module lfc_sequencer_tb_top;
    localparam int DW = 24;
    localparam int CW = 15;
    localparam int NV = 6;

    localparam logic [DW-1:0] REF_TAB [NV] = '{24'd8192, 24'd8192, 24'd8192, 24'd8192, 24'd8192, 24'd8191};
    localparam logic [CW-1:0] CNT_TAB [NV] = '{15'd8192, 15'd9102, 15'd6827, 15'd6302, 15'd16384, 15'd8192};
    localparam bit            TIK_TAB [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cnt_done = 1'b0;
    logic [CW-1:0] cnt_value = '0;
    logic div_done = 1'b0;
    logic [DW-1:0] div_quot = '0;
    logic [DW-1:0] ref_count = '0;
    logic cnt_start_o, cnt_rd_o, div_start_o, timeout_o;
    logic [DW-1:0] div_dividend_o, div_divisor_o, freq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lfc_sequencer #(.DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .cnt_start_o(cnt_start_o), .cnt_done_i(cnt_done), .cnt_rd_o(cnt_rd_o),
        .cnt_value_i(cnt_value), .div_start_o(div_start_o), .div_done_i(div_done),
        .div_dividend_o(div_dividend_o), .div_divisor_o(div_divisor_o),
        .div_quot_i(div_quot), .ref_count_i(ref_count),
        .freq_o(freq_o), .timeout_o(timeout_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One full measurement, entered and left in the count-wait state.
    task automatic measure(input logic [DW-1:0] refv, input logic [CW-1:0] cnt, input bit tick_in_div);
        longint q;
        logic [DW-1:0] expq, oldf;
        q = (longint'(refv) << 22) / longint'(cnt);
        expq = q[DW-1:0];
        ref_count = refv;
        cnt_value = cnt;
        cnt_done = 1'b1;
        step();
        cnt_done = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 no read before tick", 32'(cnt_rd_o), 32'd0);
        end
        tick = 1'b1;
        step();
        tick = 1'b0;
        chk("R3 read after tick", 32'(cnt_rd_o), 32'd1);
        step();
        chk("R4 div start", 32'(div_start_o), 32'd1);
        chk("R4 divisor", 32'(div_divisor_o), 32'(cnt));
        chk("R4 dividend", 32'(div_dividend_o), 32'(refv));
        ref_count = ~refv;
        cnt_value = ~cnt;
        step();
        chk("R4 start single", 32'(div_start_o), 32'd0);
        chk("R4 divisor held", 32'(div_divisor_o), 32'(cnt));
        chk("R4 dividend held", 32'(div_dividend_o), 32'(refv));
        for (int i = 0; i < 20; i++) step();
        if (tick_in_div) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            chk("R9 tick ignored start", 32'(cnt_start_o), 32'd0);
            chk("R9 tick ignored read", 32'(cnt_rd_o), 32'd0);
        end else begin
            step();
        end
        oldf = freq_o;
        div_quot = expq;
        div_done = 1'b1;
        step();
        div_done = 1'b0;
        chk("R5 freq not early", 32'(freq_o), 32'(oldf));
        step();
        chk("R5 freq stored", 32'(freq_o), 32'(expq));
        chk("R6 restart", 32'(cnt_start_o), 32'd1);
        chk("R8 timeout clear", 32'(timeout_o), 32'd0);
        div_quot = '1;
        step();
        chk("R2 start single", 32'(cnt_start_o), 32'd0);
        chk("R5 freq held", 32'(freq_o), 32'(expq));
    endtask

    initial begin
        logic [DW-1:0] lastf;
        repeat (3) step();
        // R1 reset state
        chk("R1 freq", 32'(freq_o), 32'd0);
        chk("R1 timeout", 32'(timeout_o), 32'd0);
        chk("R1 start", 32'(cnt_start_o), 32'd0);
        chk("R1 read", 32'(cnt_rd_o), 32'd0);
        chk("R1 div", 32'(div_start_o), 32'd0);
        rst_n = 1'b1;
        repeat (5) step();
        chk("R1 idle without tick", 32'(cnt_start_o), 32'd0);
        // R2 first start
        tick = 1'b1;
        step();
        tick = 1'b0;
        chk("R2 start on tick", 32'(cnt_start_o), 32'd1);
        step();
        chk("R2 start one cycle", 32'(cnt_start_o), 32'd0);
        // Vector table walk
        for (int v = 0; v < NV; v++) measure(REF_TAB[v], CNT_TAB[v], TIK_TAB[v]);
        lastf = freq_o;
        // R7 timeout: tick with no count
        repeat (4) step();
        tick = 1'b1;
        step();
        tick = 1'b0;
        chk("R7 timeout set", 32'(timeout_o), 32'd1);
        chk("R7 restart", 32'(cnt_start_o), 32'd1);
        chk("R7 freq kept", 32'(freq_o), 32'(lastf));
        step();
        repeat (3) step();
        chk("R8 timeout sticky", 32'(timeout_o), 32'd1);
        // R3 done and tick in the same cycle
        ref_count = 24'd8192;
        cnt_value = 15'd8192;
        cnt_done = 1'b1;
        tick = 1'b1;
        step();
        cnt_done = 1'b0;
        tick = 1'b0;
        chk("R3 same-cycle read", 32'(cnt_rd_o), 32'd1);
        step();
        step();
        div_quot = 24'h400000;
        div_done = 1'b1;
        step();
        div_done = 1'b0;
        step();
        chk("R5 freq 50Hz", 32'(freq_o), 32'h400000);
        chk("R8 timeout cleared", 32'(timeout_o), 32'd0);
        step();
        // R1 reset mid-run
        rst_n = 1'b0;
        repeat (2) step();
        chk("R1 freq after reset", 32'(freq_o), 32'd0);
        rst_n = 1'b1;
        cnt_done = 1'b1;
        step();
        cnt_done = 1'b0;
        repeat (3) step();
        chk("R1 no start without tick", 32'(cnt_start_o), 32'd0);
        chk("R1 no read without tick", 32'(cnt_rd_o), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule